// File: doc/BRIEF.md
# Serial Flash Identity Probe

This block runs a single identity-read exchange with a serial NOR flash through a byte-wide SPI engine and decides whether the part is the one expected. It does not generate SCK or shift bits; a separate shifter clocks each byte out of `tx_byte_o` and into `rx_byte_i` (MSB first, SPI mode 0 or 3) and pulses `byte_done_i` once per byte. After a one-cycle `start_i`, the block lowers chip select and offers the identity opcode. It then sends filler bytes while it gathers the three identity bytes the flash returns. When the last byte arrives it raises chip select and pulses `done_o`. At the same time `pass_o` shows whether all three bytes equal the parameterised expected codes.

The controller has four states. In `ST_IDLE` chip select is high and the block waits. `start_i` moves it to `ST_OPCODE`, where chip select is low and the opcode is presented. The first byte strobe moves it to `ST_IDREAD`, where filler is presented and bytes are captured. The third capture strobe moves it to `ST_FINISH`, which lasts one cycle, holds chip select high and asserts `done_o`. The next state is always `ST_IDLE`. No other transitions exist. The captured bytes and the verdict stay valid until the next accepted start.

Top module: `flash_id_probe`

## Requirements
- R1: After reset `cs_n_o` is 1, `done_o` is 0, `pass_o` is 0, `tx_byte_o` is 0x00 and all three ID outputs are 0x00.
- R2: A `start_i` pulse accepted while idle makes `cs_n_o` 0 and `tx_byte_o` 0x9F in the next cycle.
- R3: After the byte strobe that completes the opcode, `tx_byte_o` is 0x00 and `cs_n_o` stays 0 while the identity bytes are read.
- R4: The next three byte strobes load `rx_byte_i` into `id_mfr_o`, `id_type_o` and `id_cap_o`, in that order.
- R5: `cs_n_o` stays 0 until the third identity strobe and is 1 from the following cycle. `done_o` is 1 in that same cycle.
- R6: In the `done_o` cycle, `pass_o` is 1 exactly when the three bytes equal EXP_MFR, EXP_TYPE and EXP_CAP (defaults 0x20, 0x20, 0x15). Any single mismatch gives 0.
- R7: `pass_o` and the ID outputs hold their values until the next accepted start. That start clears all four to 0 in the following cycle.
- R8: `start_i` is ignored while an exchange is in progress, including in the `done_o` cycle.
- R9: `byte_done_i` is ignored while idle: chip select, ID outputs and verdict do not change.
- R10: `done_o` is high for exactly one clock per exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an identity exchange |
| byte_done_i | input | 1 | Byte engine strobe: one byte has been shifted |
| rx_byte_i | input | 8 | Byte received by the engine, valid with the strobe |
| tx_byte_o | output | 8 | Byte for the engine to shift out next |
| cs_n_o | output | 1 | Flash chip select, active low; also the transfer request |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Identity matched expected codes |
| id_mfr_o | output | 8 | Captured manufacturer byte |
| id_type_o | output | 8 | Captured memory-type byte |
| id_cap_o | output | 8 | Captured capacity byte |

## Verification
The bound checker checks these rules on every cycle:
- an idle start opens chip select with the opcode;
- `done_o` coincides with chip select high and never lasts two cycles;
- a start in the `done_o` cycle is dropped;
- idle strobes neither open chip select nor change the verdict.

Capture order, the filler byte, the match decision for each byte and the rejection of starts in the middle of an exchange depend on byte values across a whole exchange. Only the bench's directed and random exchanges can show them, because it compares the captured bytes and verdict against its own model.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
    localparam logic [7:0] RDID_OPCODE = 8'h9F;
    localparam logic [7:0] FILL_BYTE   = 8'h00;
    localparam int         ID_LEN      = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_IDREAD,
        ST_FINISH
    } probe_state_e;
endpackage

// File: rtl/flash_id_seq.sv
module flash_id_seq
    import flash_id_pkg::*;
#(
    parameter  int ID_LEN_P = ID_LEN,
    localparam int IDX_W    = (ID_LEN_P > 1) ? $clog2(ID_LEN_P) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             byte_done_i,
    output logic             cs_n_o,
    output logic [7:0]       tx_byte_o,
    output logic             done_o,
    output logic             accept_o,
    output logic             cap_en_o,
    output logic [IDX_W-1:0] cap_idx_o,
    output logic             cap_last_o
);
    probe_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    // strobe bookkeeping toward the capture bank
    assign accept_o   = (state_q == ST_IDLE) && start_i;
    assign cap_en_o   = (state_q == ST_IDREAD) && byte_done_i;
    assign cap_idx_o  = idx_q;
    assign cap_last_o = cap_en_o && (idx_q == IDX_W'(ID_LEN_P - 1));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)     state_d = ST_OPCODE;
            ST_OPCODE: if (byte_done_i) state_d = ST_IDREAD;
            ST_IDREAD: if (cap_last_o)  state_d = ST_FINISH;
            ST_FINISH:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // identity byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         idx_q <= '0;
        else if (accept_o)  idx_q <= '0;
        else if (cap_en_o)  idx_q <= cap_last_o ? '0 : idx_q + 1'b1;
    end

    // outputs decoded from state
    always_comb begin
        cs_n_o    = 1'b1;
        tx_byte_o = FILL_BYTE;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_OPCODE: begin cs_n_o = 1'b0; tx_byte_o = RDID_OPCODE; end
            ST_IDREAD: cs_n_o = 1'b0;
            ST_FINISH: done_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/flash_id_capture.sv
module flash_id_capture
    import flash_id_pkg::*;
#(
    parameter  logic [7:0] EXP_MFR  = 8'h20,
    parameter  logic [7:0] EXP_TYPE = 8'h20,
    parameter  logic [7:0] EXP_CAP  = 8'h15,
    localparam int         IDX_W    = $clog2(ID_LEN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic                   cap_en_i,
    input  logic [IDX_W-1:0]       cap_idx_i,
    input  logic                   cap_last_i,
    input  logic [7:0]             rx_byte_i,
    output logic [ID_LEN-1:0][7:0] id_o,
    output logic                   pass_o
);
    localparam logic [ID_LEN-1:0][7:0] EXP_VEC = {EXP_CAP, EXP_TYPE, EXP_MFR};

    logic [ID_LEN-1:0] slot_hit;

    for (genvar g = 0; g < ID_LEN; g++) begin : g_slot
        logic [7:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    slot_q <= '0;
            else if (clear_i)                              slot_q <= '0;
            else if (cap_en_i && cap_idx_i == IDX_W'(g))   slot_q <= rx_byte_i;
        end

        assign id_o[g] = slot_q;

        // last slot is compared straight from the incoming byte
        if (g == ID_LEN - 1) begin : g_tail
            assign slot_hit[g] = (rx_byte_i == EXP_VEC[g]);
        end else begin : g_body
            assign slot_hit[g] = (slot_q == EXP_VEC[g]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pass_o <= 1'b0;
        else if (clear_i)    pass_o <= 1'b0;
        else if (cap_last_i) pass_o <= &slot_hit;
    end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
    import flash_id_pkg::*;
#(
    parameter logic [7:0] EXP_MFR  = 8'h20,
    parameter logic [7:0] EXP_TYPE = 8'h20,
    parameter logic [7:0] EXP_CAP  = 8'h15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       byte_done_i,
    input  logic [7:0] rx_byte_i,
    output logic [7:0] tx_byte_o,
    output logic       cs_n_o,
    output logic       done_o,
    output logic       pass_o,
    output logic [7:0] id_mfr_o,
    output logic [7:0] id_type_o,
    output logic [7:0] id_cap_o
);
    localparam int IDX_W = $clog2(ID_LEN);

    logic                   accept;
    logic                   cap_en;
    logic                   cap_last;
    logic [IDX_W-1:0]       cap_idx;
    logic [ID_LEN-1:0][7:0] id_bank;

    flash_id_seq #(.ID_LEN_P(ID_LEN)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .byte_done_i (byte_done_i),
        .cs_n_o      (cs_n_o),
        .tx_byte_o   (tx_byte_o),
        .done_o      (done_o),
        .accept_o    (accept),
        .cap_en_o    (cap_en),
        .cap_idx_o   (cap_idx),
        .cap_last_o  (cap_last)
    );

    flash_id_capture #(
        .EXP_MFR  (EXP_MFR),
        .EXP_TYPE (EXP_TYPE),
        .EXP_CAP  (EXP_CAP)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept),
        .cap_en_i   (cap_en),
        .cap_idx_i  (cap_idx),
        .cap_last_i (cap_last),
        .rx_byte_i  (rx_byte_i),
        .id_o       (id_bank),
        .pass_o     (pass_o)
    );

    assign id_mfr_o  = id_bank[0];
    assign id_type_o = id_bank[1];
    assign id_cap_o  = id_bank[2];
endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       byte_done_i,
    input logic [7:0] rx_byte_i,
    input logic [7:0] tx_byte_o,
    input logic       cs_n_o,
    input logic       done_o,
    input logic       pass_o,
    input logic [7:0] id_mfr_o,
    input logic [7:0] id_type_o,
    input logic [7:0] id_cap_o
);
    assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o && !done_o && start_i) |=> (!cs_n_o && tx_byte_o == 8'h9F));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cs_n_o);

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> cs_n_o);

    assert_idle_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o && !done_o && !start_i) |=> (cs_n_o && $stable(pass_o)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o && !done_o && !start_i) |=>
            ($stable(id_mfr_o) && $stable(id_type_o) && $stable(id_cap_o)));
endmodule

bind flash_id_probe flash_id_probe_chk u_chk (.*);

// File: tb/flash_id_probe_test.sv
module flash_id_probe_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic       byte_done_i;
    logic [7:0] rx_byte_i;
    logic [7:0] tx_byte_o;
    logic       cs_n_o;
    logic       done_o;
    logic       pass_o;
    logic [7:0] id_mfr_o;
    logic [7:0] id_type_o;
    logic [7:0] id_cap_o;

    int checks = 0;
    int bad    = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    flash_id_probe uut (.*);

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic bit model_pass(logic [7:0] m, logic [7:0] t, logic [7:0] c);
        return (m == 8'h20) && (t == 8'h20) && (c == 8'h15);
    endfunction

    task automatic strobe(logic [7:0] b);
        byte_done_i = 1'b1;
        rx_byte_i   = b;
        @(negedge clk);
        byte_done_i = 1'b0;
        rx_byte_i   = 8'($urandom);
    endtask

    // idle gap; a noisy run may drop a start pulse into it
    task automatic gap(bit noisy, int n);
        for (int i = 0; i < n; i++) begin
            start_i = noisy && (i == 0);
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    task automatic run(logic [7:0] m, logic [7:0] t, logic [7:0] c, bit noisy, bit tight);
        logic [7:0] bytes [3];
        bit exp;
        bytes[0] = m; bytes[1] = t; bytes[2] = c;
        exp = model_pass(m, t, c);

        chk1("R2 idle cs_n before start", cs_n_o, 1'b1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk1("R2 cs_n low after start", cs_n_o, 1'b0);
        chk8("R2 opcode", tx_byte_o, 8'h9F);
        chk8("R7 mfr cleared by start", id_mfr_o, 8'h00);
        chk1("R7 pass cleared by start", pass_o, 1'b0);

        gap(noisy, tight ? 0 : $urandom_range(1, 3));
        strobe(8'hFF);
        chk8("R3 filler byte", tx_byte_o, 8'h00);
        chk1("R3 cs_n held low", cs_n_o, 1'b0);

        for (int k = 0; k < 3; k++) begin
            gap(noisy, tight ? 0 : $urandom_range(1, 3));
            strobe(bytes[k]);
            if (k < 2) begin
                chk1("R5 cs_n low mid-read", cs_n_o, 1'b0);
                chk8("R3 filler mid-read", tx_byte_o, 8'h00);
            end
        end

        chk1("R5 done after last byte", done_o, 1'b1);
        chk1("R5 cs_n high after last byte", cs_n_o, 1'b1);
        chk8("R4 mfr", id_mfr_o, m);
        chk8("R4 type", id_type_o, t);
        chk8("R4 cap", id_cap_o, c);
        chk1("R6 verdict", pass_o, exp);

        start_i = noisy;
        @(negedge clk);
        start_i = 1'b0;
        chk1("R10 done one cycle", done_o, 1'b0);
        chk1("R8 start in done cycle ignored", cs_n_o, 1'b1);
        chk1("R7 verdict held", pass_o, exp);

        strobe(8'hA5);
        chk1("R9 idle strobe cs_n", cs_n_o, 1'b1);
        chk8("R9 idle strobe mfr", id_mfr_o, m);
        chk8("R9 idle strobe cap", id_cap_o, c);
        chk1("R9 idle strobe verdict", pass_o, exp);
        gap(1'b0, $urandom_range(0, 2));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n       = 1'b0;
        start_i     = 1'b0;
        byte_done_i = 1'b0;
        rx_byte_i   = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk1("R1 reset cs_n", cs_n_o, 1'b1);
        chk1("R1 reset done", done_o, 1'b0);
        chk1("R1 reset pass", pass_o, 1'b0);
        chk8("R1 reset tx", tx_byte_o, 8'h00);
        chk8("R1 reset mfr", id_mfr_o, 8'h00);
        chk8("R1 reset type", id_type_o, 8'h00);
        chk8("R1 reset cap", id_cap_o, 8'h00);

        // directed corners
        run(8'h20, 8'h20, 8'h15, 1'b0, 1'b0);
        run(8'h21, 8'h20, 8'h15, 1'b1, 1'b0);
        run(8'h20, 8'h21, 8'h15, 1'b0, 1'b1);
        run(8'h20, 8'h20, 8'h16, 1'b1, 1'b1);
        run(8'h15, 8'h20, 8'h20, 1'b0, 1'b0);
        run(8'h20, 8'h20, 8'h15, 1'b1, 1'b1);

        // random exchanges, half of them genuine
        for (int n = 0; n < 40; n++) begin
            if ($urandom_range(0, 1) == 1)
                run(8'h20, 8'h20, 8'h15, 1'($urandom), 1'($urandom));
            else
                run(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule